// File: doc/BRIEF.md
# Three-Mode Power State Controller

This block decides which power mode a processor core is in and drives the two controls that put that mode into effect: a core clock enable and a main-supply enable. It has three steady modes. In run, the clock and supply are both on. In idle, the clock is gated and the supply stays on, so the always-on logic keeps working. In sleep, the supply is cut. Requests to enter idle or sleep, and wake events, come in as plain level inputs. They are sampled on every clock in which the controller sits in a steady mode.

Each move between modes takes a fixed number of timer ticks, and each kind of move has its own parameter. Run-to-idle and idle-to-run are short. Run-to-sleep is of medium length and is split into three shutdown steps of equal length. Sleep-to-run is the longest. While a move is in progress the controller reports that it is busy, shows the transitional mode code and ignores all requests. A timer tick input paces the moves and the residency counting. The block keeps one saturating counter for each steady mode, holding the ticks spent in that mode. All pins are plain control and status signals. No data passes through the block, so it has no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset puts the block in run. In run, mode_code is 2'b00, core_clk_en and main_pwr_en are 1, busy is 0 and shutdown_step is 0. All residency counters clear to 0 on reset.
- R2: In run, an idle request starts a run-to-idle move that lasts T_IDLE ticks. During the move mode_code is 2'b11 and core_clk_en stays 1. The move ends in idle, where mode_code is 2'b01, core_clk_en is 0 and main_pwr_en is 1.
- R3: In idle, a wake event starts an idle-to-run move that lasts T_IDLE ticks. During the move core_clk_en is 0 and main_pwr_en is 1. The move ends in run.
- R4: In run, a sleep request starts a run-to-sleep move that lasts T_ENTER_SLEEP ticks. The move passes through three steps, and shutdown_step reads 1, then 2, then 3. Steps 1 and 2 each last T_ENTER_SLEEP/3 ticks, and step 3 also takes any remainder. core_clk_en is 1 only in step 1, and main_pwr_en is 0 in step 3. The move ends in sleep, where mode_code is 2'b10 and both enables are 0.
- R5: Sleep is left only by a wake event, and always through a sleep-to-run move that lasts T_WAKE ticks. During that move main_pwr_en is 1 and core_clk_en is 0. Idle and sleep requests have no effect in sleep.
- R6: In run, a sleep request takes priority over an idle request that arrives in the same cycle. A wake event has no effect in run. Idle and sleep requests have no effect in idle.
- R7: busy is 1 exactly while a move is in progress. Any request or wake event that arrives while busy is 1 is ignored and changes neither the length of the move nor the mode it ends in.
- R8: A move advances only on cycles in which tick is 1. Cycles without a tick lengthen the move in clock cycles but not in ticks.
- R9: Each residency counter (run, idle, sleep) adds one for each tick cycle spent in its steady mode. It does not count during moves or on cycles without a tick, and it saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick that paces moves and residency counting |
| idle_req | input | 1 | Request to enter idle, sampled in run |
| sleep_req | input | 1 | Request to enter sleep, sampled in run |
| wake_evt | input | 1 | Wake event, sampled in idle and sleep |
| core_clk_en | output | 1 | Core clock enable |
| main_pwr_en | output | 1 | Main supply enable |
| mode_code | output | 2 | 00 run, 01 idle, 10 sleep, 11 transitioning |
| busy | output | 1 | High during any move |
| shutdown_step | output | 2 | Current shutdown step 1..3 during run-to-sleep, 0 otherwise |
| res_run | output | CNT_W | Ticks spent in run |
| res_idle | output | CNT_W | Ticks spent in idle |
| res_sleep | output | CNT_W | Ticks spent in sleep |

## Verification
Two functions can fall in the same cycle. The first is arbitration between an idle request and a sleep request that arrive together in run. The bench raises both for one cycle and accepts the result only if the shutdown steps start at once and the move lasts the full run-to-sleep length. The second is the clash between a move in progress and new requests. The bench pulses sleep requests and wake events in the middle of a run-to-idle move, then counts busy cycles and reads the final mode code. A correct block shows exactly T_IDLE busy cycles and then ends in idle.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_SLEEP,
    ST_RUN2IDLE,
    ST_IDLE2RUN,
    ST_RUN2SLEEP,
    ST_SLEEP2RUN
  } pstate_t;

  localparam logic [1:0] MC_RUN   = 2'b00;
  localparam logic [1:0] MC_IDLE  = 2'b01;
  localparam logic [1:0] MC_SLEEP = 2'b10;
  localparam logic [1:0] MC_TRANS = 2'b11;

  localparam int NUM_MODES = 3;

endpackage

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] remain,
  output logic          done
);

  // Counts down one per tick; done marks the tick that consumes the last unit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (tick && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign done = tick && (remain == TW'(1));

endmodule

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int TW            = 8,
  parameter int T_IDLE        = 10,
  parameter int T_ENTER_SLEEP = 90,
  parameter int T_WAKE        = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req,
  input  logic          sleep_req,
  input  logic          wake_evt,
  input  logic          done,
  output pstate_t       state,
  output logic          load,
  output logic [TW-1:0] load_val
);

  pstate_t nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_RUN: begin
        if (sleep_req) begin
          nxt      = ST_RUN2SLEEP;
          load     = 1'b1;
          load_val = TW'(T_ENTER_SLEEP);
        end else if (idle_req) begin
          nxt      = ST_RUN2IDLE;
          load     = 1'b1;
          load_val = TW'(T_IDLE);
        end
      end
      ST_IDLE: begin
        if (wake_evt) begin
          nxt      = ST_IDLE2RUN;
          load     = 1'b1;
          load_val = TW'(T_IDLE);
        end
      end
      ST_SLEEP: begin
        if (wake_evt) begin
          nxt      = ST_SLEEP2RUN;
          load     = 1'b1;
          load_val = TW'(T_WAKE);
        end
      end
      ST_RUN2IDLE:  if (done) nxt = ST_IDLE;
      ST_IDLE2RUN:  if (done) nxt = ST_RUN;
      ST_RUN2SLEEP: if (done) nxt = ST_SLEEP;
      ST_SLEEP2RUN: if (done) nxt = ST_RUN;
      default:      nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

endmodule

// File: rtl/pwr_residency.sv
`timescale 1ns/1ps
module pwr_residency #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (en && count != '1)  count <= count + 1'b1;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int T_IDLE        = 10,
  parameter int T_ENTER_SLEEP = 90,
  parameter int T_WAKE        = 160,
  parameter int CNT_W         = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             idle_req,
  input  logic             sleep_req,
  input  logic             wake_evt,
  output logic             core_clk_en,
  output logic             main_pwr_en,
  output logic [1:0]       mode_code,
  output logic             busy,
  output logic [1:0]       shutdown_step,
  output logic [CNT_W-1:0] res_run,
  output logic [CNT_W-1:0] res_idle,
  output logic [CNT_W-1:0] res_sleep
);

  localparam int T_MAX01  = (T_IDLE > T_ENTER_SLEEP) ? T_IDLE : T_ENTER_SLEEP;
  localparam int T_MAX    = (T_MAX01 > T_WAKE) ? T_MAX01 : T_WAKE;
  localparam int TW       = $clog2(T_MAX + 1);
  localparam int STEP_LEN = T_ENTER_SLEEP / 3;

  pstate_t       state;
  logic          load, done;
  logic [TW-1:0] load_val, remain, elapsed;
  logic          in_r2s;

  pwr_fsm #(
    .TW(TW), .T_IDLE(T_IDLE), .T_ENTER_SLEEP(T_ENTER_SLEEP), .T_WAKE(T_WAKE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .done(done), .state(state), .load(load),
    .load_val(load_val)
  );

  pwr_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(load_val), .remain(remain), .done(done)
  );

  // Shutdown step from ticks already spent in the run-to-sleep move.
  assign in_r2s  = (state == ST_RUN2SLEEP);
  assign elapsed = TW'(T_ENTER_SLEEP) - remain;

  always_comb begin
    if (!in_r2s)                              shutdown_step = 2'd0;
    else if (elapsed < TW'(STEP_LEN))         shutdown_step = 2'd1;
    else if (elapsed < TW'(2 * STEP_LEN))     shutdown_step = 2'd2;
    else                                      shutdown_step = 2'd3;
  end

  always_comb begin
    unique case (state)
      ST_RUN:   mode_code = MC_RUN;
      ST_IDLE:  mode_code = MC_IDLE;
      ST_SLEEP: mode_code = MC_SLEEP;
      default:  mode_code = MC_TRANS;
    endcase
  end

  assign busy        = (mode_code == MC_TRANS);
  assign core_clk_en = (state == ST_RUN) || (state == ST_RUN2IDLE) ||
                       (shutdown_step == 2'd1);
  assign main_pwr_en = (state != ST_SLEEP) && (shutdown_step != 2'd3);

  logic [CNT_W-1:0] res_cnt [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_res
    pwr_residency #(.CNT_W(CNT_W)) u_res (
      .clk(clk), .rst_n(rst_n),
      .en(tick && (mode_code == 2'(m))),
      .count(res_cnt[m])
    );
  end

  assign res_run   = res_cnt[0];
  assign res_idle  = res_cnt[1];
  assign res_sleep = res_cnt[2];

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             idle_req,
  input logic             sleep_req,
  input logic             wake_evt,
  input logic             core_clk_en,
  input logic             main_pwr_en,
  input logic [1:0]       mode_code,
  input logic             busy,
  input logic [1:0]       shutdown_step,
  input logic [CNT_W-1:0] res_run,
  input logic [CNT_W-1:0] res_idle,
  input logic [CNT_W-1:0] res_sleep
);

  AST_RUN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00) |-> (core_clk_en && main_pwr_en && !busy)); // R1

  AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b01) |-> (!core_clk_en && main_pwr_en)); // R2

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b10) |-> (!core_clk_en && !main_pwr_en)); // R4

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_step != 2'd0) |=> (shutdown_step == 2'd0 ||
                                 shutdown_step >= $past(shutdown_step))); // R4

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b10 && !wake_evt) |=> (mode_code == 2'b10)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b01 && !wake_evt) |=> (mode_code == 2'b01)); // R6

  AST_SLEEP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00 && sleep_req) |=> (shutdown_step == 2'd1)); // R6

  AST_STEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_step != 2'd0) |-> busy); // R7

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(shutdown_step))); // R8

  AST_RES_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_run >= $past(res_run) && res_idle >= $past(res_idle) &&
              res_sleep >= $past(res_sleep))); // R9

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .idle_req(idle_req),
  .sleep_req(sleep_req), .wake_evt(wake_evt), .core_clk_en(core_clk_en),
  .main_pwr_en(main_pwr_en), .mode_code(mode_code), .busy(busy),
  .shutdown_step(shutdown_step), .res_run(res_run), .res_idle(res_idle),
  .res_sleep(res_sleep)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

  localparam int TI   = 10;
  localparam int TS   = 90;
  localparam int TWK  = 160;
  localparam int CW   = 8;
  localparam int STEP = TS / 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic idle_req = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
  logic core_clk_en, main_pwr_en, busy;
  logic [1:0] mode_code, shutdown_step;
  logic [CW-1:0] res_run, res_idle, res_sleep;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(
    .T_IDLE(TI), .T_ENTER_SLEEP(TS), .T_WAKE(TWK), .CNT_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle_req(idle_req),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .core_clk_en(core_clk_en),
    .main_pwr_en(main_pwr_en), .mode_code(mode_code), .busy(busy),
    .shutdown_step(shutdown_step), .res_run(res_run), .res_idle(res_idle),
    .res_sleep(res_sleep)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic i, input logic s, input logic w);
    idle_req = i; sleep_req = s; wake_evt = w;
    cyc();
    idle_req = 0; sleep_req = 0; wake_evt = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 2000) begin
      cyc();
      n++;
    end
  endtask

  task automatic t_reset();
    check("R1", "mode", mode_code, 0);
    check("R1", "clk_en", core_clk_en, 1);
    check("R1", "pwr_en", main_pwr_en, 1);
    check("R1", "busy", busy, 0);
    check("R1", "step", shutdown_step, 0);
    check("R1", "res_run", res_run, 0);
    check("R1", "res_idle", res_idle, 0);
    check("R1", "res_sleep", res_sleep, 0);
  endtask

  task automatic t_run_to_idle();
    int n;
    pulse(1, 0, 0);
    check("R2", "busy in move", busy, 1);
    check("R2", "mode in move", mode_code, 3);
    check("R2", "clk_en in move", core_clk_en, 1);
    busy_len(n);
    check("R2", "move length", n, TI);
    check("R2", "idle mode", mode_code, 1);
    check("R2", "idle clk_en", core_clk_en, 0);
    check("R2", "idle pwr_en", main_pwr_en, 1);
  endtask

  task automatic t_idle_ignore();
    logic [CW-1:0] v0;
    pulse(0, 1, 0);
    check("R6", "idle ignores sleep_req", mode_code, 1);
    pulse(1, 0, 0);
    check("R6", "idle ignores idle_req", mode_code, 1);
    check("R6", "idle busy", busy, 0);
    v0 = res_idle;
    repeat (5) cyc();
    check("R9", "idle residency", int'(res_idle), int'(v0) + 5);
  endtask

  task automatic t_idle_to_run();
    int n;
    pulse(0, 0, 1);
    check("R3", "busy", busy, 1);
    check("R3", "clk_en in move", core_clk_en, 0);
    check("R3", "pwr_en in move", main_pwr_en, 1);
    busy_len(n);
    check("R3", "move length", n, TI);
    check("R3", "run mode", mode_code, 0);
    check("R3", "run clk_en", core_clk_en, 1);
  endtask

  task automatic t_run_ignore_wake();
    pulse(0, 0, 1);
    check("R6", "run ignores wake mode", mode_code, 0);
    check("R6", "run ignores wake busy", busy, 0);
  endtask

  task automatic t_sleep_entry();
    int bad = 0;
    pulse(1, 1, 0);
    check("R6", "sleep wins first step", shutdown_step, 1);
    for (int k = 0; k < TS; k++) begin
      int es = (k < STEP) ? 1 : (k < 2 * STEP) ? 2 : 3;
      if (shutdown_step != 2'(es) || core_clk_en != (es == 1) ||
          main_pwr_en != (es != 3) || !busy || mode_code != 2'b11) begin
        if (bad == 0)
          check("R4", $sformatf("step at tick %0d", k), shutdown_step, es);
        bad++;
      end
      cyc();
    end
    check("R4", "step mismatches", bad, 0);
    check("R4", "sleep mode", mode_code, 2);
    check("R4", "sleep clk_en", core_clk_en, 0);
    check("R4", "sleep pwr_en", main_pwr_en, 0);
    check("R4", "sleep step", shutdown_step, 0);
  endtask

  task automatic t_sleep_ignore();
    logic [CW-1:0] v0;
    pulse(1, 0, 0);
    check("R5", "sleep ignores idle_req", mode_code, 2);
    pulse(0, 1, 0);
    check("R5", "sleep ignores sleep_req", mode_code, 2);
    v0 = res_sleep;
    repeat (5) cyc();
    check("R9", "sleep residency", int'(res_sleep), int'(v0) + 5);
  endtask

  task automatic t_wake();
    int n;
    pulse(0, 0, 1);
    check("R5", "wake busy", busy, 1);
    check("R5", "wake pwr_en", main_pwr_en, 1);
    check("R5", "wake clk_en", core_clk_en, 0);
    busy_len(n);
    check("R5", "wake length", n, TWK);
    check("R5", "back to run", mode_code, 0);
  endtask

  task automatic t_ignore_busy();
    int n = 0;
    pulse(1, 0, 0);
    while (busy && n < 2000) begin
      sleep_req = (n == 3);
      wake_evt  = (n == 5);
      cyc();
      n++;
    end
    sleep_req = 0; wake_evt = 0;
    check("R7", "move length with requests", n, TI);
    check("R7", "end mode", mode_code, 1);
    pulse(0, 0, 1);
    busy_len(n);
  endtask

  task automatic t_tick_gate();
    int n;
    logic [CW-1:0] v0;
    tick = 0;
    pulse(1, 0, 0);
    repeat (20) cyc();
    check("R8", "still moving without ticks", mode_code, 3);
    tick = 1;
    busy_len(n);
    check("R8", "ticks to finish", n, TI);
    tick = 0;
    v0 = res_idle;
    repeat (5) cyc();
    check("R9", "no count without tick", int'(res_idle), int'(v0));
    tick = 1;
    pulse(0, 0, 1);
    busy_len(n);
    check("R8", "back to run", mode_code, 0);
  endtask

  task automatic t_saturate();
    repeat (300) cyc();
    check("R9", "run residency saturates", int'(res_run), (1 << CW) - 1);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    tick = 1'b1;
    t_run_to_idle();
    t_idle_ignore();
    t_idle_to_run();
    t_run_ignore_wake();
    t_sleep_entry();
    t_sleep_ignore();
    t_wake();
    t_ignore_busy();
    t_tick_gate();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule